// File: doc/BRIEF.md
# Debug Stall Status Register

This block is an 8-bit memory-mapped control and status register for a CPU debug unit. Software uses it to switch single-step mode on and off. It also reads back why the CPU was stalled: a completed single step, the stall that holds the CPU right after reset, or a hit on either of two breakpoint comparators. For breakpoint stalls it also keeps the direction (read or write) of the access that caused the break.

The register watches a level stall input. On the first cycle of a stall it samples single-cycle cause pulses from the step and breakpoint logic and records every cause that is present. When the stall ends, all cause flags clear together. The direction flag is the exception: it keeps its value until the next breakpoint stall. The breakpoint comparators, their condition decoding and the stall mechanism itself live outside this block.

Bus reads are combinational. The read data shows the register image while the address matches the register's decode address, and reads as zero otherwise. Bus writes take effect at the next clock edge.

Top module: `dbg_stall_status`

## Requirements
- R1: While reset is asserted, and right after it, the register reads 0x10 and `step_en_o` is 0.
- R2: A bus write at address `REG_ADDR` loads bit 6 (step enable, also driven on `step_en_o`) from write data bit 6 at the next clock edge. A write at any other address changes nothing.
- R3: Bus writes never change bits 5..1. Bits 7 and 0 always read 0.
- R4: A read at any address other than `REG_ADDR` returns 0x00.
- R5: In the cycle where the stall input rises (low in the previous cycle, high now), each cause pulse sets its own flag at that clock edge: step to bit 5, breakpoint 1 to bit 1, breakpoint 2 to bit 2. When several pulses are present, all of their flags are set. Cause pulses in any other cycle are ignored.
- R6: At a stall rise with a pulse on breakpoint 1 or breakpoint 2, bit 3 takes `access_rd_i` (1 = read, 0 = write). In every other case bit 3 holds its value, including across stall release.
- R7: In the cycle where the stall input falls (high in the previous cycle, low now), bits 5, 4, 2 and 1 clear at that clock edge. Bits 6 and 3 are not affected.
- R8: Reset counts as the start of a stall. The reset flag (bit 4) stays 1 until the first clock edge after reset at which the stall input is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data (combinational) |
| stall_i | input | 1 | CPU stall level from the debug unit |
| step_hit_i | input | 1 | Single-step completion pulse |
| bkpt1_hit_i | input | 1 | Breakpoint 1 match pulse |
| bkpt2_hit_i | input | 1 | Breakpoint 2 match pulse |
| access_rd_i | input | 1 | Direction of the current access, 1 = read |
| step_en_o | output | 1 | Step mode enable |

## Verification
On every cycle, the in-line assertions check four things: the reserved bits stay zero, the cause flags hold between stall edges, a falling stall clears all cause flags, and a rising stall with a breakpoint pulse loads both the breakpoint flag and the direction. The bench scenarios cover what needs a whole sequence to show. These are the reset flag surviving a held post-reset stall, the direction flag kept across release and across a step-only stall, writes at a foreign address, and all causes landing together. Seeded random traffic is compared against a bench model on every cycle.

// File: rtl/dbg_stall_status.sv
module dbg_stall_status #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              stall_i,
  input  logic              step_hit_i,
  input  logic              bkpt1_hit_i,
  input  logic              bkpt2_hit_i,
  input  logic              access_rd_i,
  output logic              step_en_o
);
  localparam int EN_BIT = 6;

  logic step_en_q, step_f_q, rst_f_q, dir_f_q, bk2_f_q, bk1_f_q, stall_q;
  logic hit, rise, fall, bk_any;

  assign hit    = (bus_addr_i == REG_ADDR);
  assign rise   = stall_i & ~stall_q;
  assign fall   = stall_q & ~stall_i;
  assign bk_any = bkpt1_hit_i | bkpt2_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q   <= 1'b1;
      step_en_q <= 1'b0;
      step_f_q  <= 1'b0;
      rst_f_q   <= 1'b1;
      dir_f_q   <= 1'b0;
      bk2_f_q   <= 1'b0;
      bk1_f_q   <= 1'b0;
    end else begin
      stall_q <= stall_i;
      if (bus_wr_i && hit) step_en_q <= bus_wdata_i[EN_BIT];
      if (fall) begin
        step_f_q <= 1'b0;
        rst_f_q  <= 1'b0;
        bk2_f_q  <= 1'b0;
        bk1_f_q  <= 1'b0;
      end
      if (rise) begin
        if (step_hit_i)  step_f_q <= 1'b1;
        if (bkpt2_hit_i) bk2_f_q  <= 1'b1;
        if (bkpt1_hit_i) bk1_f_q  <= 1'b1;
        if (bk_any)      dir_f_q  <= access_rd_i;
      end
    end
  end

  assign step_en_o   = step_en_q;
  assign bus_rdata_o = hit ? {1'b0, step_en_q, step_f_q, rst_f_q, dir_f_q, bk2_f_q, bk1_f_q, 1'b0}
                           : 8'h00;

  always_comb assert_reserved_zero_R3: assert (bus_rdata_o[7] == 1'b0 && bus_rdata_o[0] == 1'b0);

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !fall) |=> $stable({step_f_q, rst_f_q, bk2_f_q, bk1_f_q}));

  assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> ({step_f_q, rst_f_q, bk2_f_q, bk1_f_q} == 4'b0000));

  assert_bk1_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bkpt1_hit_i) |=> bk1_f_q);

  assert_dir_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && bk_any) |=> (dir_f_q == $past(access_rd_i)));

  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && bk_any) |=> $stable(dir_f_q));

  assert_step_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && hit) |=> (step_en_o == $past(bus_wdata_i[EN_BIT])));
endmodule

// File: tb/dbg_stall_status_tb.sv
module dbg_stall_status_tb;
  localparam int PERIOD = 10;
  localparam logic [7:0] RA = 8'h18;

  logic clk = 0, rst_n = 0;
  logic wr = 0, st = 0, sh = 0, b1 = 0, b2 = 0, dir = 0;
  logic [7:0] addr = 0, wd = 0, rd;
  logic en_o;
  int checks = 0, fails = 0;
  bit done = 0;

  logic m_en, m_sf, m_rf, m_dir, m_b2, m_b1, m_sq;

  always #(PERIOD/2) clk = ~clk;

  dbg_stall_status #(.ADDR_W(8), .REG_ADDR(RA)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wd),
    .bus_rdata_o(rd), .stall_i(st), .step_hit_i(sh), .bkpt1_hit_i(b1),
    .bkpt2_hit_i(b2), .access_rd_i(dir), .step_en_o(en_o));

  function automatic logic [7:0] image();
    return {1'b0, m_en, m_sf, m_rf, m_dir, m_b2, m_b1, 1'b0};
  endfunction

  task automatic model_reset();
    m_en = 0; m_sf = 0; m_rf = 1; m_dir = 0; m_b2 = 0; m_b1 = 0; m_sq = 1;
  endtask

  task automatic model_step();
    logic r, f;
    r = st & ~m_sq;
    f = m_sq & ~st;
    if (wr && addr == RA) m_en = wd[6];
    if (f) begin m_sf = 0; m_rf = 0; m_b2 = 0; m_b1 = 0; end
    if (r) begin
      if (sh) m_sf = 1;
      if (b1) m_b1 = 1;
      if (b2) m_b2 = 1;
      if (b1 || b2) m_dir = dir;
    end
    m_sq = st;
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic w, logic [7:0] a, logic [7:0] d, logic s,
                     logic p_st, logic p1, logic p2, logic dr);
    wr = w; addr = a; wd = d; st = s; sh = p_st; b1 = p1; b2 = p2; dir = dr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr = 0; sh = 0; b1 = 0; b2 = 0;
  endtask

  task automatic look(string tag);
    addr = RA;
    #1;
    chk(tag, rd, image());
    chk(tag, {7'd0, en_o}, {7'd0, m_en});
  endtask

  initial begin
    model_reset();
    st = 1;
    repeat (3) @(negedge clk);
    look("R1 in reset");
    chk("R1 literal", rd, 8'h10);
    rst_n = 1;
    cyc(0, RA, 0, 1, 0, 0, 0, 0);
    look("R8 held stall keeps reset flag");
    chk("R8 literal", rd, 8'h10);
    cyc(0, RA, 0, 0, 0, 0, 0, 0);
    look("R8 release clears reset flag");
    chk("R7 literal", rd, 8'h00);
    cyc(1, RA, 8'hFF, 0, 0, 0, 0, 0);
    look("R2 write all ones");
    chk("R3 only enable written", rd, 8'h40);
    cyc(1, 8'h19, 8'h00, 0, 0, 0, 0, 0);
    look("R2 foreign address write ignored");
    addr = 8'h19; #1;
    chk("R4 foreign read", rd, 8'h00);
    cyc(0, RA, 0, 1, 1, 1, 1, 1);
    look("R5 all causes at once");
    chk("R6 read direction literal", rd, 8'h6E);
    cyc(1, RA, 8'h00, 1, 0, 0, 0, 0);
    look("R3 write keeps flags");
    chk("R3 literal", rd, 8'h2E);
    cyc(0, RA, 0, 1, 1, 1, 0, 0);
    look("R5 pulse without edge ignored");
    cyc(0, RA, 0, 0, 0, 0, 0, 0);
    look("R7 release");
    chk("R6 direction kept on release", rd, 8'h08);
    cyc(0, RA, 0, 1, 1, 0, 0, 0);
    look("R6 step-only stall keeps direction");
    chk("R5 step literal", rd, 8'h28);
    cyc(0, RA, 0, 0, 0, 0, 0, 0);
    cyc(0, RA, 0, 1, 0, 0, 1, 0);
    look("R6 write direction");
    chk("R6 literal", rd, 8'h04);

    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ra;
      ra = ($urandom % 4 == 0) ? 8'($urandom) : RA;
      cyc(($urandom % 3) == 0, ra, 8'($urandom), ($urandom % 4) != 0,
          ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
          ($urandom % 2) == 0);
      look("R5 R7 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule